// File: doc/BRIEF.md
# Serial Synthesizer Configuration Port

This block is the programming front end of a clock synthesizer. Three slow serial wires (a shift clock, a data line and a load strobe) are sampled by the chip's system clock. Each rising edge of the shift clock moves the data bit into a 15-bit shift register. The load strobe moves the shifted frame into the configuration the synthesizer runs from. That configuration has four fields: a 9-bit feedback divide value, a 3-bit output divide code, a spread-spectrum enable and a 2-bit selector for a test pin.

The load strobe has two roles. Its rising edge copies the shift register into the configuration. While it stays high, every shift-clock edge also updates the configuration, so the path is transparent. Its falling edge freezes the configuration until the next load. The test pin can show nothing, the shift register's last stage (for reading a frame back), the feedback-divider output or the divided output clock. The block also flags a feedback value that lies outside the range the loop can lock to, while still applying that value.

Top module: `serial_synth_cfg`

## Requirements
- R1: While `mr` is high, and after it falls, the configuration is feedback 192, divide code 000, spread off and test select 01. The shift register is all zero, so `test_out` is 0.
- R2: While `s_load` is low, each rising edge of `s_clock` shifts `s_data` into the shift register, and the configuration outputs do not change.
- R3: The frame is sent with test select bit 1 first. After 15 shifts the register reads, from its last stage down: test select [1:0], divide code [2:0], feedback [8:0] (MSB first), spread enable.
- R4: A rising edge of `s_load` copies the shift register into the configuration outputs.
- R5: While `s_load` is high, each rising edge of `s_clock` shifts the register and updates the configuration to the new register value.
- R6: After `s_load` falls, the configuration holds while further bits are shifted.
- R7: Test select 00 drives `test_out` low.
- R8: Test select 01 drives `test_out` with the shift register's last stage: the bit sent 15 shifts earlier, or 0 if fewer bits have been sent since reset.
- R9: Test select 10 passes `mdiv_clk_in` to `test_out`. Test select 11 passes `outdiv_clk_in`.
- R10: `m_out_of_range` is high exactly when the applied feedback value is below 120 or above 336. The value is still driven on `m_div`.
- R11: `mr` asserted in the middle of a frame restores the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| mr | input | 1 | Active-high asynchronous master reset |
| s_clock | input | 1 | Serial shift clock |
| s_data | input | 1 | Serial data line |
| s_load | input | 1 | Load strobe: rise transfers, high is transparent, fall freezes |
| mdiv_clk_in | input | 1 | Feedback-divider output, used as a test source |
| outdiv_clk_in | input | 1 | Divided output clock, used as a test source |
| m_div | output | 9 | Applied feedback divide value |
| n_code | output | 3 | Applied output divide code |
| ssc_en | output | 1 | Spread-spectrum enable |
| test_sel | output | 2 | Applied test pin selector |
| test_out | output | 1 | Test pin |
| m_out_of_range | output | 1 | Feedback value outside 120..336 |

## Verification
The hardest state to reach is transparent mode while the test selector is itself being rewritten. In that state each shifted bit changes which source drives the test pin. The stimulus raises the load strobe first and then shifts a frame through. After every bit it checks the configuration and the pin against a bench model of the shift register. Feedback values are swept across both lock-range boundaries, and every output divide code is used with alternating spread settings.

// File: rtl/serial_synth_cfg_pkg.sv
package serial_synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 3;
  localparam int T_W     = 2;
  localparam int FRAME_W = T_W + N_W + M_W + 1;

  // Field order matches the serial frame: first bit sent sits in the MSB.
  typedef struct packed {
    logic [T_W-1:0] tsel;
    logic [N_W-1:0] ncode;
    logic [M_W-1:0] mdiv;
    logic           ssc;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{tsel: 2'b01, ncode: '0, mdiv: M_W'(192), ssc: 1'b0};

  function automatic logic m_in_range(input logic [M_W-1:0] m, input int lo, input int hi);
    return (int'(m) >= lo) && (int'(m) <= hi);
  endfunction
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         mr,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or posedge mr) begin
      if (mr) pipe <= '0;
      else    pipe <= {pipe[STAGES-1:0], din[i]};
    end
    assign lvl[i]  = pipe[STAGES-1];
    assign rise[i] = pipe[STAGES-1] & ~pipe[STAGES];
  end
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         mr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] sr,
  output logic [W-1:0] sr_next
);
  assign sr_next = shift_en ? {sr[W-2:0], din} : sr;

  always_ff @(posedge clk or posedge mr) begin
    if (mr) sr <= '0;
    else    sr <= sr_next;
  end
endmodule

// File: rtl/scfg_cfg_reg.sv
module scfg_cfg_reg
  import serial_synth_cfg_pkg::*;
#(
  parameter int M_MIN = 120,
  parameter int M_MAX = 336
) (
  input  logic clk,
  input  logic mr,
  input  logic upd,
  input  cfg_t d,
  output cfg_t q,
  output logic oor
);
  always_ff @(posedge clk or posedge mr) begin
    if (mr)       q <= CFG_RESET;
    else if (upd) q <= d;
  end

  assign oor = !m_in_range(q.mdiv, M_MIN, M_MAX);
endmodule

// File: rtl/scfg_test_mux.sv
module scfg_test_mux #(
  parameter int T_W = 2
) (
  input  logic [T_W-1:0] sel,
  input  logic           readback,
  input  logic           mdiv_clk,
  input  logic           outdiv_clk,
  output logic           y
);
  always_comb begin
    unique case (sel)
      2'b00:   y = 1'b0;
      2'b01:   y = readback;
      2'b10:   y = mdiv_clk;
      default: y = outdiv_clk;
    endcase
  end
endmodule

// File: rtl/serial_synth_cfg.sv
module serial_synth_cfg
  import serial_synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_MIN       = 120,
  parameter int M_MAX       = 336
) (
  input  logic           clk,
  input  logic           mr,
  input  logic           s_clock,
  input  logic           s_data,
  input  logic           s_load,
  input  logic           mdiv_clk_in,
  input  logic           outdiv_clk_in,
  output logic [M_W-1:0] m_div,
  output logic [N_W-1:0] n_code,
  output logic           ssc_en,
  output logic [T_W-1:0] test_sel,
  output logic           test_out,
  output logic           m_out_of_range
);
  localparam int IDX_CLK  = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_LOAD = 2;

  logic [2:0] s_lvl, s_rise;
  logic shift_evt, load_now, load_rise, cfg_upd;
  logic [FRAME_W-1:0] sr_word, sr_next;
  cfg_t cfg_q;

  scfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .mr(mr), .din({s_load, s_data, s_clock}),
    .lvl(s_lvl), .rise(s_rise)
  );

  // Named events for the checker.
  assign shift_evt = s_rise[IDX_CLK];
  assign load_now  = s_lvl[IDX_LOAD];
  assign load_rise = s_rise[IDX_LOAD];
  assign cfg_upd   = load_now && (load_rise || shift_evt);

  scfg_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .mr(mr), .shift_en(shift_evt), .din(s_lvl[IDX_DATA]),
    .sr(sr_word), .sr_next(sr_next)
  );

  scfg_cfg_reg #(.M_MIN(M_MIN), .M_MAX(M_MAX)) u_cfg (
    .clk(clk), .mr(mr), .upd(cfg_upd), .d(cfg_t'(sr_next)),
    .q(cfg_q), .oor(m_out_of_range)
  );

  scfg_test_mux #(.T_W(T_W)) u_mux (
    .sel(cfg_q.tsel), .readback(sr_word[FRAME_W-1]),
    .mdiv_clk(mdiv_clk_in), .outdiv_clk(outdiv_clk_in), .y(test_out)
  );

  assign m_div    = cfg_q.mdiv;
  assign n_code   = cfg_q.ncode;
  assign ssc_en   = cfg_q.ssc;
  assign test_sel = cfg_q.tsel;
endmodule

// File: rtl/serial_synth_cfg_chk.sv
module serial_synth_cfg_chk
  import serial_synth_cfg_pkg::*;
#(
  parameter int M_MIN = 120,
  parameter int M_MAX = 336
) (
  input logic               clk,
  input logic               mr,
  input logic               shift_evt,
  input logic               load_now,
  input logic               load_rise,
  input logic [FRAME_W-1:0] sr_word,
  input cfg_t               cfg_q,
  input logic               test_out,
  input logic               oor
);
  localparam logic [FRAME_W-1:0] DEF_WORD = {2'b01, 3'b000, 9'd192, 1'b0};

  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (mr)
    $past(mr) |-> (FRAME_W'(cfg_q) == DEF_WORD && sr_word == '0));

  assert_shift_only_on_edge_R2: assert property (@(posedge clk) disable iff (mr)
    !shift_evt |=> $stable(sr_word));

  assert_transfer_R4: assert property (@(posedge clk) disable iff (mr)
    (load_rise && !shift_evt) |=> (FRAME_W'(cfg_q) == $past(sr_word)));

  assert_transparent_R5: assert property (@(posedge clk) disable iff (mr)
    (load_now && shift_evt) |=> (FRAME_W'(cfg_q) == sr_word));

  assert_hold_R6: assert property (@(posedge clk) disable iff (mr)
    !load_now |=> $stable(cfg_q));

  assert_test_low_R7: assert property (@(posedge clk) disable iff (mr)
    (cfg_q.tsel == 2'b00) |-> !test_out);

  assert_readback_R8: assert property (@(posedge clk) disable iff (mr)
    (cfg_q.tsel == 2'b01) |-> (test_out == sr_word[FRAME_W-1]));

  assert_in_range_clear_R10: assert property (@(posedge clk) disable iff (mr)
    (int'(cfg_q.mdiv) >= M_MIN && int'(cfg_q.mdiv) <= M_MAX) |-> !oor);
endmodule

bind serial_synth_cfg serial_synth_cfg_chk #(.M_MIN(M_MIN), .M_MAX(M_MAX)) u_chk (
  .clk(clk), .mr(mr), .shift_evt(shift_evt), .load_now(load_now),
  .load_rise(load_rise), .sr_word(sr_word), .cfg_q(cfg_q),
  .test_out(test_out), .oor(m_out_of_range)
);

// File: tb/serial_synth_cfg_test.sv
module serial_synth_cfg_test;
  logic clk = 1'b0;
  logic mr = 1'b1;
  logic s_clock = 1'b0, s_data = 1'b0, s_load = 1'b0;
  logic mdiv_clk_in = 1'b0, outdiv_clk_in = 1'b0;
  logic [8:0] m_div;
  logic [2:0] n_code;
  logic ssc_en, test_out, m_out_of_range;
  logic [1:0] test_sel;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [14:0] sr_m = '0;
  logic [14:0] cfg_m = {2'b01, 3'b000, 9'd192, 1'b0};
  bit load_m = 0;

  always #5 clk = ~clk;

  serial_synth_cfg uut (
    .clk(clk), .mr(mr), .s_clock(s_clock), .s_data(s_data), .s_load(s_load),
    .mdiv_clk_in(mdiv_clk_in), .outdiv_clk_in(outdiv_clk_in),
    .m_div(m_div), .n_code(n_code), .ssc_en(ssc_en), .test_sel(test_sel),
    .test_out(test_out), .m_out_of_range(m_out_of_range)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_oor(logic [8:0] m);
    return (m < 9'd120) || (m > 9'd336);
  endfunction

  function automatic logic exp_test(logic [14:0] c, logic [14:0] s);
    case (c[14:13])
      2'b00:   return 1'b0;
      2'b01:   return s[14];
      2'b10:   return mdiv_clk_in;
      default: return outdiv_clk_in;
    endcase
  endfunction

  task automatic chk_cfg(string tag);
    chk({tag, " m_div"}, m_div, cfg_m[9:1]);
    chk({tag, " n_code"}, n_code, cfg_m[12:10]);
    chk({tag, " ssc"}, ssc_en, cfg_m[0]);
    chk({tag, " tsel"}, test_sel, cfg_m[14:13]);
    chk({tag, " oor R10"}, m_out_of_range, exp_oor(cfg_m[9:1]));
  endtask

  task automatic send_bit(logic b);
    s_data = b;
    tick(4);
    s_clock = 1'b1;
    sr_m = {sr_m[13:0], b};
    if (load_m) cfg_m = sr_m;
    tick(4);
    s_clock = 1'b0;
    tick(4);
    chk("R8 test pin after shift", test_out, exp_test(cfg_m, sr_m));
  endtask

  task automatic send_frame(logic [14:0] f, string tag);
    for (int i = 14; i >= 0; i--) send_bit(f[i]);
    chk_cfg(tag);
  endtask

  task automatic load_up;
    s_load = 1'b1;
    tick(5);
    cfg_m = sr_m;
    load_m = 1;
  endtask

  task automatic load_down;
    s_load = 1'b0;
    tick(5);
    load_m = 0;
  endtask

  function automatic logic [14:0] mk(logic [1:0] t, logic [2:0] n, logic [8:0] m, logic s);
    return {t, n, m, s};
  endfunction

  initial begin
    tick(4);
    chk_cfg("R1 during reset");
    mr = 1'b0;
    tick(3);
    chk_cfg("R1 after reset");
    chk("R1 test pin zero", test_out, 1'b0);

    // R2/R8: shift a frame with load low; config must not move.
    send_frame(mk(2'b01, 3'd5, 9'd200, 1'b1), "R2 hold while shifting");
    load_up;
    chk_cfg("R4 transfer / R3 field order");
    load_down;
    chk_cfg("R6 after load fall");

    // R6: more shifting after load falls.
    send_frame(15'h5A3C, "R6 frozen config");

    // R3/R10 sweep over boundary feedback values and all divide codes.
    begin
      logic [8:0] mv[12] = '{9'd0, 9'd119, 9'd120, 9'd121, 9'd192, 9'd255,
                             9'd300, 9'd335, 9'd336, 9'd337, 9'd400, 9'd511};
      for (int k = 0; k < 12; k++) begin
        send_frame(mk(2'b01, 3'(k % 8), mv[k], 1'(k % 2)), "R2 sweep shift");
        load_up;
        chk_cfg("R3 R10 sweep load");
        load_down;
      end
    end

    // R5: transparent mode, config follows each bit.
    load_up;
    for (int i = 14; i >= 0; i--) begin
      logic [14:0] f = mk(2'b10, 3'd6, 9'd333, 1'b1);
      send_bit(f[i]);
      chk_cfg("R5 transparent");
    end
    load_down;
    send_frame(15'h7FFF, "R6 after transparent");

    // R7: select 00 with ones in the register and both sources high.
    send_frame(mk(2'b00, 3'd1, 9'd150, 1'b0), "R7 pre");
    load_up; load_down;
    send_frame(15'h7FFF, "R7 shift ones");
    mdiv_clk_in = 1'b1; outdiv_clk_in = 1'b1; #1;
    chk("R7 test low", test_out, 1'b0);

    // R9: select 10 then 11.
    send_frame(mk(2'b10, 3'd2, 9'd160, 1'b0), "R9 pre a");
    load_up; load_down;
    for (int v = 0; v < 4; v++) begin
      mdiv_clk_in = v[0]; outdiv_clk_in = v[1]; #1;
      chk("R9 mdiv passthrough", test_out, v[0]);
    end
    send_frame(mk(2'b11, 3'd3, 9'd170, 1'b1), "R9 pre b");
    load_up; load_down;
    for (int v = 0; v < 4; v++) begin
      mdiv_clk_in = v[0]; outdiv_clk_in = v[1]; #1;
      chk("R9 outdiv passthrough", test_out, v[1]);
    end

    // R11: reset mid-frame.
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    mr = 1'b1;
    #2;
    sr_m = '0;
    cfg_m = {2'b01, 3'b000, 9'd192, 1'b0};
    chk_cfg("R11 async reset");
    tick(2);
    mr = 1'b0;
    tick(3);
    chk_cfg("R11 after reset");
    chk("R11 readback cleared", test_out, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule